// File: doc/BRIEF.md
# Packet Memory Pointer and Data Window

This block lets a host reach the packet buffer RAM through two small registers instead of a flat memory window. The host first loads a pointer that holds a byte offset inside a packet, a flag choosing which packet to address, an auto-advance flag and a read-direction flag. It then moves data through a single data register, as a 16-bit word or as one byte, and the block turns each access into a word access on the packet RAM.

There are two sources for the packet. One is the packet number that the receive queue presents at its head. The other is a packet number the host writes into its own packet-number register. An external lookup port converts the chosen packet number into the base page of that packet. A page is 256 bytes, and the RAM byte address is the base page times 256 plus the offset. With auto-advance set, the offset steps forward after each data access. In read mode a small fetch machine keeps one word prefetched at the current offset. The machine has three states. ST_READY is idle with the prefetched word valid. ST_ISSUE drives the RAM read. ST_CAPTURE loads the returned word. Its transitions are as follows. A start (a pointer write with the read flag set, or an accepted data access in read mode with auto-advance) moves any state to ST_ISSUE. A cancel (a pointer write with the read flag clear) moves any state to ST_READY. ST_ISSUE always moves to ST_CAPTURE, and ST_CAPTURE always moves to ST_READY.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the pointer and packet-number registers read as zero, `data_ready` is 1, and `mem_re` and `mem_we` are 0.
- R2: The register select `host_reg` picks the pointer at code 0, the packet-number register at code 1 and the data register at code 2. In the pointer, bit 15 selects the receive-queue head, bit 14 enables auto-advance, bit 13 sets read mode and bits 10:0 are the byte offset. Reading the pointer returns these fields with bits 12:11 zero. Reading code 1 returns the packet number, zero-extended.
- R3: A data access addresses the RAM word at byte address (base page × 256 + offset), taken modulo the RAM size, with bit 0 dropped. The base page is `lut_page` for `lut_pkt`, and `lut_pkt` is `rx_head_pkt` when pointer bit 15 is 1 and the packet-number register when it is 0.
- R4: A word write stores `host_wdata[15:0]`. A byte write stores `host_wdata[7:0]` in the low byte when offset bit 0 is 0 and in the high byte when it is 1, and leaves the other byte unchanged.
- R5: With auto-advance set, the offset grows by 2 after a word access and by 1 after a byte access, and wraps modulo 2048. With auto-advance clear, the offset does not change.
- R6: A pointer write with the read flag set drives `data_ready` low for exactly two cycles. After that, a word read of the data register returns the RAM word at the new offset.
- R7: A byte read returns the addressed byte (high byte for an odd offset) in bits 7:0, with bits 15:8 zero.
- R8: In read mode with auto-advance, each accepted data read advances the offset and drops `data_ready` for two cycles while the word at the new offset is fetched.
- R9: A data access made while `data_ready` is low is ignored. Nothing is written to the RAM and the offset does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_reg | input | 2 | Register select: 0 pointer, 1 packet number, 2 data |
| host_byte | input | 1 | 1 for a byte data access, 0 for a word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected register |
| data_ready | output | 1 | Data register accepts accesses and holds valid read data |
| rx_head_pkt | input | PKT_W | Packet number at the head of the receive queue |
| lut_pkt | output | PKT_W | Packet number sent to the page lookup |
| lut_page | input | PAGE_W | Base page returned by the lookup |
| mem_addr | output | PAGE_W+7 | RAM word address |
| mem_re | output | 1 | RAM read; data is returned one cycle later |
| mem_we | output | 1 | RAM write |
| mem_be | output | 2 | RAM byte enables (bit 0 low byte) |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data |

## Verification
If the fetch machine were stuck or skipped a state, the ready flag would show it within two cycles of the pointer write. A prefetch from the wrong word would show as wrong data on the first read after ready returns. An offset that advances by the wrong step or fails to wrap puts the next write in the wrong RAM word, and the error can be seen at once on the RAM port and on pointer read-back. A wrong packet selection changes the lookup output in the same cycle, so data goes to or comes from another packet's page.

// File: rtl/pktport_pkg.sv
package pktport_pkg;
    localparam int OFS_W       = 11;
    localparam int PTR_RX_BIT  = 15;
    localparam int PTR_INC_BIT = 14;
    localparam int PTR_RD_BIT  = 13;

    typedef enum logic [1:0] {
        REG_PTR  = 2'd0,
        REG_PNR  = 2'd1,
        REG_DATA = 2'd2
    } host_reg_e;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_CAPTURE = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/pkt_ptr_reg.sv
module pkt_ptr_reg
    import pktport_pkg::*;
#(
    parameter int PKT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_we,
    input  logic             pnr_we,
    input  logic             adv,
    input  logic             adv_byte,
    input  logic [15:0]      wdata,
    output logic             rx_sel,
    output logic             auto_inc,
    output logic             rd_mode,
    output logic [OFS_W-1:0] offset,
    output logic [PKT_W-1:0] pnr
);
    logic [OFS_W-1:0] step;

    always_comb begin
        step = adv_byte ? OFS_W'(1) : OFS_W'(2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sel   <= 1'b0;
            auto_inc <= 1'b0;
            rd_mode  <= 1'b0;
            offset   <= '0;
        end else if (ptr_we) begin
            rx_sel   <= wdata[PTR_RX_BIT];
            auto_inc <= wdata[PTR_INC_BIT];
            rd_mode  <= wdata[PTR_RD_BIT];
            offset   <= wdata[OFS_W-1:0];
        end else if (adv) begin
            offset   <= offset + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pnr <= '0;
        end else if (pnr_we) begin
            pnr <= wdata[PKT_W-1:0];
        end
    end
endmodule

// File: rtl/pkt_fetch_fsm.sv
module pkt_fetch_fsm
    import pktport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        cancel,
    input  logic [15:0] mem_rdata,
    output logic        mem_re,
    output logic        ready,
    output logic [15:0] word_buf
);
    fetch_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        if (start) begin
            st_nx = ST_ISSUE;
        end else if (cancel) begin
            st_nx = ST_READY;
        end else begin
            unique case (st)
                ST_READY:   st_nx = ST_READY;
                ST_ISSUE:   st_nx = ST_CAPTURE;
                ST_CAPTURE: st_nx = ST_READY;
                default:    st_nx = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_READY;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 word_buf <= '0;
        else if (st == ST_CAPTURE)  word_buf <= mem_rdata;
    end

    always_comb begin
        mem_re = (st == ST_ISSUE);
        ready  = (st == ST_READY);
    end

    // R6: a fetch that is not restarted completes in order
    a_r6_issue_to_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ISSUE && !start && !cancel) |=> (st == ST_CAPTURE));
    a_r6_capture_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE && !start) |=> ready);
endmodule

// File: rtl/pkt_mem_map.sv
module pkt_mem_map
    import pktport_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic [PAGE_W-1:0] base_page,
    input  logic [OFS_W-1:0]  offset,
    input  logic              byte_mode,
    input  logic [15:0]       wdata,
    output logic [PAGE_W+6:0] word_addr,
    output logic [1:0]        be,
    output logic [15:0]       lane_wdata
);
    localparam int BA_W = PAGE_W + 8;

    logic [BA_W-1:0] byte_addr;

    always_comb begin
        byte_addr  = {base_page, 8'h00} + BA_W'(offset);
        word_addr  = byte_addr[BA_W-1:1];
        be         = byte_mode ? (offset[0] ? 2'b10 : 2'b01) : 2'b11;
        lane_wdata = byte_mode ? {wdata[7:0], wdata[7:0]} : wdata;
    end
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
    import pktport_pkg::*;
#(
    parameter int PKT_W  = 6,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_reg,
    input  logic              host_byte,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              data_ready,
    input  logic [PKT_W-1:0]  rx_head_pkt,
    output logic [PKT_W-1:0]  lut_pkt,
    input  logic [PAGE_W-1:0] lut_page,
    output logic [PAGE_W+6:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);
    logic             ptr_we, pnr_we, acc, acc_ok, adv, start, cancel;
    logic             rx_sel, auto_inc, rd_mode;
    logic [OFS_W-1:0] offset;
    logic [PKT_W-1:0] pnr;
    logic [15:0]      word_buf;

    always_comb begin
        ptr_we = host_wr && (host_reg == REG_PTR);
        pnr_we = host_wr && (host_reg == REG_PNR);
        acc    = (host_wr || host_rd) && (host_reg == REG_DATA);
        acc_ok = acc && data_ready;
        adv    = acc_ok && auto_inc;
        start  = (ptr_we && host_wdata[PTR_RD_BIT]) || (adv && rd_mode);
        cancel = ptr_we && !host_wdata[PTR_RD_BIT];
        lut_pkt = rx_sel ? rx_head_pkt : pnr;
        mem_we  = host_wr && (host_reg == REG_DATA) && data_ready;
    end

    pkt_ptr_reg #(.PKT_W(PKT_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_we   (ptr_we),
        .pnr_we   (pnr_we),
        .adv      (adv),
        .adv_byte (host_byte),
        .wdata    (host_wdata),
        .rx_sel   (rx_sel),
        .auto_inc (auto_inc),
        .rd_mode  (rd_mode),
        .offset   (offset),
        .pnr      (pnr)
    );

    pkt_fetch_fsm u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cancel    (cancel),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .ready     (data_ready),
        .word_buf  (word_buf)
    );

    pkt_mem_map #(.PAGE_W(PAGE_W)) u_map (
        .base_page  (lut_page),
        .offset     (offset),
        .byte_mode  (host_byte),
        .wdata      (host_wdata),
        .word_addr  (mem_addr),
        .be         (mem_be),
        .lane_wdata (mem_wdata)
    );

    always_comb begin
        host_rdata = '0;
        unique case (host_reg)
            REG_PTR:  host_rdata = {rx_sel, auto_inc, rd_mode, 2'b00, offset};
            REG_PNR:  host_rdata = 16'(pnr);
            REG_DATA: host_rdata = host_byte
                                   ? {8'h00, (offset[0] ? word_buf[15:8] : word_buf[7:0])}
                                   : word_buf;
            default:  host_rdata = '0;
        endcase
    end

    // R9: accesses while the fetch is busy leave the offset alone
    a_r9_busy_keeps_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !data_ready) |=> $stable(offset));
    // R5: word step of two under auto-advance
    a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && auto_inc && !host_byte) |=> (offset == OFS_W'($past(offset) + OFS_W'(2))));
    // R4: a byte write touches exactly one lane
    a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && host_byte) |-> ($countones(mem_be) == 1));
    // R6: the cycle after a RAM read the data register is not ready
    a_r6_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !ptr_we) |=> !data_ready);
endmodule

// File: tb/tb_pkt_data_port.sv
`timescale 1ns/1ps
module tb_pkt_data_port;
    localparam int PKT_W  = 6;
    localparam int PAGE_W = 4;
    localparam int MEM_AW = PAGE_W + 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0, host_rd = 1'b0, host_byte = 1'b0;
    logic [1:0]        host_reg = 2'd0;
    logic [15:0]       host_wdata = '0;
    logic [15:0]       host_rdata;
    logic              data_ready;
    logic [PKT_W-1:0]  rx_head_pkt = '0;
    logic [PKT_W-1:0]  lut_pkt;
    logic [PAGE_W-1:0] lut_page;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_re, mem_we;
    logic [1:0]        mem_be;
    logic [15:0]       mem_wdata, mem_rdata;

    logic [15:0] ram [2**MEM_AW];
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pkt_data_port #(.PKT_W(PKT_W), .PAGE_W(PAGE_W)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_reg(host_reg), .host_byte(host_byte), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .data_ready(data_ready), .rx_head_pkt(rx_head_pkt),
        .lut_pkt(lut_pkt), .lut_page(lut_page), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int page_of(int pkt);
        return (pkt * 5 + 3) % 16;
    endfunction

    function automatic int widx(int pkt, int ofs);
        return ((page_of(pkt) * 256 + ofs) % 4096) >> 1;
    endfunction

    assign lut_page = PAGE_W'(page_of(int'(lut_pkt)));

    always_ff @(posedge clk) begin
        if (mem_we) begin
            if (mem_be[0]) ram[mem_addr][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) ram[mem_addr][15:8] <= mem_wdata[15:8];
        end
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] r, logic b, logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_reg = r; host_byte = b; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_data(logic b, output logic [15:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_reg = 2'd2; host_byte = b;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek(logic [1:0] r, output logic [15:0] d);
        host_reg = r; host_byte = 1'b0;
        #1 d = host_rdata;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 10 && !data_ready; i++) @(negedge clk);
    endtask

    typedef struct packed { logic [7:0] pkt; logic [15:0] ofs; logic [15:0] data; } vec_t;
    localparam vec_t VECS [4] = '{
        '{8'd1,  16'h0000, 16'h0A01},
        '{8'd2,  16'h0010, 16'h0B02},
        '{8'd9,  16'h0104, 16'h0C03},
        '{8'd12, 16'h07FE, 16'h0D04}
    };

    logic [15:0] v;

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2**MEM_AW; i++) ram[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", {15'd0, data_ready}, 16'd1);
        check("R1 mem idle", {14'd0, mem_re, mem_we}, 16'd0);
        peek(2'd0, v); check("R1 pointer", v, 16'h0000);
        peek(2'd1, v); check("R1 pnr", v, 16'h0000);

        // R3 R4 R2: vector table of word writes
        foreach (VECS[k]) begin
            wr(2'd1, 1'b0, 16'(VECS[k].pkt));
            wr(2'd0, 1'b0, VECS[k].ofs);
            peek(2'd0, v); check("R2 pointer readback", v, VECS[k].ofs);
            peek(2'd1, v); check("R2 pnr readback", v, 16'(VECS[k].pkt));
            wr(2'd2, 1'b0, VECS[k].data);
            @(negedge clk);
            check("R3 word placement", ram[widx(VECS[k].pkt, VECS[k].ofs)], VECS[k].data);
        end

        // R4 byte lane on odd offset
        wr(2'd1, 1'b0, 16'd3);
        wr(2'd0, 1'b0, 16'h0020); wr(2'd2, 1'b0, 16'h1234);
        wr(2'd0, 1'b0, 16'h0021); wr(2'd2, 1'b1, 16'h77CC);
        @(negedge clk);
        check("R4 high lane", ram[widx(3, 16'h20)], 16'hCC34);

        // R5 auto-advance by 2 and 1
        wr(2'd0, 1'b0, 16'h4040);
        wr(2'd2, 1'b0, 16'h1111); wr(2'd2, 1'b0, 16'h2222);
        wr(2'd2, 1'b1, 16'h0033); wr(2'd2, 1'b1, 16'h0044);
        @(negedge clk);
        check("R5 word 0x40", ram[widx(3, 16'h40)], 16'h1111);
        check("R5 word 0x42", ram[widx(3, 16'h42)], 16'h2222);
        check("R5 bytes 0x44", ram[widx(3, 16'h44)], 16'h4433);
        peek(2'd0, v); check("R5 offset", v, 16'h4046);

        // R5 no advance
        wr(2'd0, 1'b0, 16'h0050);
        wr(2'd2, 1'b0, 16'hAAAA); wr(2'd2, 1'b0, 16'hBBBB);
        @(negedge clk);
        check("R5 hold word", ram[widx(3, 16'h50)], 16'hBBBB);
        check("R5 hold next", ram[widx(3, 16'h52)], 16'h0000);

        // R5 wrap at 2048
        wr(2'd0, 1'b0, 16'h47FF);
        wr(2'd2, 1'b1, 16'h005A); wr(2'd2, 1'b1, 16'h006B);
        @(negedge clk);
        check("R5 wrap last byte", ram[widx(3, 16'h7FE)], 16'h5A00);
        check("R5 wrap first byte", ram[widx(3, 16'h000)], 16'h006B);
        peek(2'd0, v); check("R5 wrap offset", v, 16'h4001);

        // R6 prefetch timing and data
        wr(2'd0, 1'b0, 16'h2040);
        check("R6 busy 1", {15'd0, data_ready}, 16'd0);
        @(negedge clk);
        check("R6 busy 2", {15'd0, data_ready}, 16'd0);
        @(negedge clk);
        check("R6 ready", {15'd0, data_ready}, 16'd1);
        rd_data(1'b0, v); check("R6 word", v, 16'h1111);

        // R7 byte read at odd offset
        wr(2'd0, 1'b0, 16'h2045); wait_ready();
        rd_data(1'b1, v); check("R7 odd byte", v, 16'h0044);

        // R8 streaming read with auto-advance
        wr(2'd0, 1'b0, 16'h6040); wait_ready();
        rd_data(1'b0, v); check("R8 first", v, 16'h1111);
        check("R8 refetch busy", {15'd0, data_ready}, 16'd0);
        wait_ready();
        rd_data(1'b0, v); check("R8 second", v, 16'h2222);
        wait_ready();
        rd_data(1'b1, v); check("R8 byte even", v, 16'h0033);
        wait_ready();
        rd_data(1'b1, v); check("R8 byte odd", v, 16'h0044);
        wait_ready();
        peek(2'd0, v); check("R8 offset", v, 16'h6046);

        // R3 receive-queue head selection
        wr(2'd1, 1'b0, 16'd5);
        wr(2'd0, 1'b0, 16'h0000); wr(2'd2, 1'b0, 16'hBEEF);
        wr(2'd1, 1'b0, 16'd6);
        rx_head_pkt = 6'd5;
        wr(2'd0, 1'b0, 16'hA000); wait_ready();
        rd_data(1'b0, v); check("R3 rx head", v, 16'hBEEF);
        wr(2'd0, 1'b0, 16'h2000); wait_ready();
        rd_data(1'b0, v); check("R3 pnr select", v, 16'h0000);

        // R9 access while busy is ignored
        wr(2'd1, 1'b0, 16'd3);
        wr(2'd0, 1'b0, 16'h6060);
        wr(2'd2, 1'b0, 16'hDEAD);
        wait_ready();
        @(negedge clk);
        check("R9 no write", ram[widx(3, 16'h60)], 16'h0000);
        peek(2'd0, v); check("R9 offset kept", v, 16'h6060);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule